// File: doc/BRIEF.md
# Phase-Modulo Clock-Enable Generator

This block runs entirely in one reference clock domain and emits a single-cycle enable pulse at an average rate of the reference rate times phase divided by modulo. Each reference cycle an accumulator adds the phase value. When the sum reaches the modulo it wraps and one pulse is produced. A second output gives a divided strobe that a downstream pixel pipe uses as its pixel-valid qualifier. A divider code selects whether the strobe marks every pulse, every second pulse or every fourth pulse.

Software programs the block through a small write/read register port. It stages phase and then modulo, and sets the enable bit. It then polls a read-only status bit until the generator reports that it is running. Only after that does the downstream source-select output follow its request bit. If phase is 0 and modulo is 1 while enabled, the generator gives a clean 0 Hz output with no pulses. The pulse and strobe outputs are plain enables with no handshake. A consumer cannot apply back-pressure and must take each pulse in the cycle it appears.

Top module: `dto_clk_gen`

## Requirements
- R1: From a fresh enable or a modulo commit, the number of pulses after K accumulator updates is exactly floor(K*phase/modulo) when phase <= modulo.
- R2: While enabled with phase 0 and modulo 1, en_status is high and no pulse or strobe appears.
- R3: Phase and modulo are full 32-bit values. Any pair, including modulo values of 1e8 and 0xFFFFFFFF, gives the R1 count with no overflow.
- R4: en_status (also ctrl bit 8) rises exactly 2 cycles after the write that sets enable (ctrl bit 0), and falls 1 cycle after the write that clears it.
- R5: src_sel is high only while en_status is high. A select request (ctrl bit 1) written together with enable shows on src_sel one cycle after en_status rises.
- R6: The divider code in ctrl bits 7:4 sets the strobe: code 2 gives every fourth pulse, code 4 gives every second pulse, and code 8 or any other code gives every pulse. Counting starts at 0 on each fresh enable.
- R7: A ctrl write with enable 0 clears enable, the select request, phase and modulo to 0. The divider field takes the written value.
- R8: A phase larger than modulo is treated as equal to modulo, which gives one pulse every reference cycle.
- R9: While enabled with modulo 0, no pulse appears.
- R10: A phase write alone does not change the running ratio. A modulo write applies the staged phase and the new modulo together, and restarts the accumulator from 0.
- R11: Register addresses are 0 for ctrl, 1 for phase and 2 for modulo. After reset every register reads 0, and en_status, src_sel, dto_pulse and pix_stb are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 ctrl, 1 phase, 2 modulo) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| en_status | output | 1 | Generator running |
| dto_pulse | output | 1 | One-cycle output pulse |
| pix_stb | output | 1 | Divided pixel-valid strobe |
| src_sel | output | 1 | Downstream source select, gated by en_status |

## Verification
Random phase and modulo pairs with fixed-length windows from a fresh enable separate exact rounding from off-by-one accumulator errors. A random divider code on each pair separates the three strobe ratios. Directed patterns each target one fault class. Phase 0 over modulo 1 and modulo 0 check the silent cases. A phase above modulo checks the clamp. Values near the top of the 32-bit range expose a truncated carry. A phase-only write followed by a modulo write separates atomic commit from piecemeal update. Cycle-exact sampling around enable and disable pins down the status and select latencies.

// File: rtl/dto_pkg.sv
package dto_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PHASE = 2'd1,
    REG_MOD   = 2'd2
  } dto_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEL_BIT = 1;
  localparam int CTRL_DIV_LSB = 4;
  localparam int DIV_W        = 4;
  localparam int CTRL_ST_BIT  = 8;

  localparam logic [DIV_W-1:0] DIV_QUARTER = 4'd2;
  localparam logic [DIV_W-1:0] DIV_HALF    = 4'd4;
endpackage

// File: rtl/dto_regs.sv
module dto_regs
  import dto_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             run,
  output logic             sel_req,
  output logic [DIV_W-1:0] div_code,
  output logic [DW-1:0]    act_phase,
  output logic [DW-1:0]    act_mod,
  output logic             commit
);
  logic          en_q, st1_q;
  logic [DW-1:0] stg_phase, stg_mod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      sel_req   <= 1'b0;
      div_code  <= '0;
      stg_phase <= '0;
      stg_mod   <= '0;
      act_phase <= '0;
      act_mod   <= '0;
      commit    <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          REG_CTRL: begin
            en_q     <= wr_data[CTRL_EN_BIT];
            sel_req  <= wr_data[CTRL_EN_BIT] & wr_data[CTRL_SEL_BIT];
            div_code <= wr_data[CTRL_DIV_LSB +: DIV_W];
            if (!wr_data[CTRL_EN_BIT]) begin
              stg_phase <= '0;
              stg_mod   <= '0;
              act_phase <= '0;
              act_mod   <= '0;
            end
          end
          REG_PHASE: stg_phase <= wr_data;
          REG_MOD: begin
            stg_mod   <= wr_data;
            act_phase <= stg_phase;
            act_mod   <= wr_data;
            commit    <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // two-stage start confirmation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1_q <= 1'b0;
      run   <= 1'b0;
    end else begin
      st1_q <= en_q;
      run   <= en_q & st1_q;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: begin
        rd_data[CTRL_EN_BIT]                = en_q;
        rd_data[CTRL_SEL_BIT]               = sel_req;
        rd_data[CTRL_DIV_LSB +: DIV_W]      = div_code;
        rd_data[CTRL_ST_BIT]                = run;
      end
      REG_PHASE: rd_data = stg_phase;
      REG_MOD:   rd_data = stg_mod;
      default:   rd_data = '0;
    endcase
  end

  AST_STATUS_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(en_q, 1) && $past(en_q, 2))); // R4
  AST_STATUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |=> !run); // R4
endmodule

// File: rtl/dto_accum.sv
module dto_accum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          commit,
  input  logic [DW-1:0] phase,
  input  logic [DW-1:0] modulo,
  output logic          fire,
  output logic          pulse
);
  localparam int SW = DW + 1;

  logic [DW-1:0] acc_q, eff_phase, base;
  logic [SW-1:0] sum, wrapped;

  always_comb begin
    eff_phase = (phase > modulo) ? modulo : phase;
    base      = commit ? '0 : acc_q;
    sum       = {1'b0, base} + {1'b0, eff_phase};
    wrapped   = sum - {1'b0, modulo};
    fire      = run && (modulo != '0) && (sum >= {1'b0, modulo});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      acc_q <= '0;
      pulse <= 1'b0;
    end else begin
      acc_q <= fire ? wrapped[DW-1:0] : sum[DW-1:0];
      pulse <= fire;
    end
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !commit && modulo != '0) |-> (acc_q < modulo)); // R3
  AST_ZERO_MOD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && modulo == '0) |=> !pulse); // R9
  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(run)); // R1
endmodule

// File: rtl/dto_strobe.sv
module dto_strobe
  import dto_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fire,
  input  logic [DIV_W-1:0] div_code,
  output logic             stb
);
  logic [1:0] cnt_q, limit;

  always_comb begin
    case (div_code)
      DIV_QUARTER: limit = 2'd3;
      DIV_HALF:    limit = 2'd1;
      default:     limit = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      stb   <= 1'b0;
    end else begin
      stb <= fire && (cnt_q == limit);
      if (fire) cnt_q <= (cnt_q == limit) ? 2'd0 : cnt_q + 2'd1;
    end
  end
endmodule

// File: rtl/dto_clk_gen.sv
module dto_clk_gen
  import dto_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          en_status,
  output logic          dto_pulse,
  output logic          pix_stb,
  output logic          src_sel
);
  logic             run, sel_req, commit, fire;
  logic [DIV_W-1:0] div_code;
  logic [DW-1:0]    act_phase, act_mod;

  dto_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .run(run), .sel_req(sel_req), .div_code(div_code),
    .act_phase(act_phase), .act_mod(act_mod), .commit(commit)
  );

  dto_accum #(.DW(DW)) u_accum (
    .clk(clk), .rst_n(rst_n), .run(run), .commit(commit),
    .phase(act_phase), .modulo(act_mod), .fire(fire), .pulse(dto_pulse)
  );

  dto_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .run(run), .fire(fire),
    .div_code(div_code), .stb(pix_stb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) src_sel <= 1'b0;
    else        src_sel <= sel_req & run;
  end

  assign en_status = run;

  AST_SEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel |-> en_status); // R5
  AST_SEL_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_sel) |-> $past(en_status)); // R5
  AST_STB_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |-> dto_pulse); // R6
endmodule

// File: tb/sim_dto_clk_gen.sv
`timescale 1ns/1ps
module sim_dto_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        en_status, dto_pulse, pix_stb, src_sel;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dto_clk_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .en_status(en_status), .dto_pulse(dto_pulse), .pix_stb(pix_stb),
    .src_sel(src_sel)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_pulses(input int k, input longint p, input longint m);
    longint pe;
    if (m == 0) return 0;
    pe = (p > m) ? m : p;
    return (longint'(k) * pe) / m;
  endfunction

  function automatic longint exp_strobes(input longint np, input int code);
    if (code == 2) return np / 4;
    if (code == 4) return np / 2;
    return np;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic count(input int k, output int np, output int ns);
    np = 0; ns = 0;
    repeat (k) begin
      @(posedge clk); @(negedge clk);
      if (dto_pulse) np++;
      if (pix_stb) ns++;
    end
  endtask

  task automatic wait_status();
    int guard = 0;
    while (!en_status && guard < 20) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic start(input logic [31:0] p, input logic [31:0] m, input int code, input bit sel);
    wr(2'd0, 32'(code) << 4);
    wr(2'd1, p);
    wr(2'd2, m);
    wr(2'd0, (32'(code) << 4) | (32'(sel) << 1) | 32'd1);
    wait_status();
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int np, ns;
    int codes [3] = '{2, 4, 8};
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(2'd0, d); chk(d == 0, "R11 ctrl", d, 0);
    rd(2'd1, d); chk(d == 0, "R11 phase", d, 0);
    rd(2'd2, d); chk(d == 0, "R11 modulo", d, 0);
    chk(!en_status && !src_sel && !dto_pulse && !pix_stb, "R11 outputs",
        {en_status, src_sel, dto_pulse, pix_stb}, 0);

    // R4 / R5 cycle-exact enable
    wr(2'd0, 32'h80); wr(2'd1, 32'd1); wr(2'd2, 32'd2);
    wr(2'd0, 32'h83);
    chk(!en_status, "R4 status T+0", en_status, 0);
    @(negedge clk); chk(!en_status, "R4 status T+1", en_status, 0);
    @(negedge clk); chk(en_status, "R4 status T+2", en_status, 1);
    chk(!src_sel, "R5 sel before", src_sel, 0);
    rd(2'd0, d); chk(d[8], "R4 ctrl status bit", d[8], 1);
    @(negedge clk); chk(src_sel, "R5 sel after", src_sel, 1);

    // R7 / R4 disable
    wr(2'd0, 32'h40);
    @(negedge clk);
    chk(!en_status, "R4 status fall", en_status, 0);
    chk(!src_sel, "R7 sel cleared", src_sel, 0);
    rd(2'd0, d); chk(d == 32'h40, "R7 ctrl keeps div", d, 32'h40);
    rd(2'd1, d); chk(d == 0, "R7 phase cleared", d, 0);
    rd(2'd2, d); chk(d == 0, "R7 modulo cleared", d, 0);

    // R2 0 Hz
    start(32'd0, 32'd1, 8, 1'b0);
    chk(en_status, "R2 status", en_status, 1);
    count(100, np, ns);
    chk(np == 0 && ns == 0, "R2 zero pulses", np + ns, 0);

    // R9 modulo zero
    start(32'd5, 32'd0, 8, 1'b0);
    count(100, np, ns);
    chk(np == 0, "R9 modulo zero", np, 0);

    // R8 clamp
    start(32'd10, 32'd3, 8, 1'b0);
    count(50, np, ns);
    chk(np == 50, "R8 clamp", np, 50);

    // R6 odd code acts as full
    start(32'd1, 32'd3, 5, 1'b0);
    count(90, np, ns);
    chk(np == 30, "R1 pulses code5", np, 30);
    chk(ns == 30, "R6 odd code full", ns, 30);

    // R3 large values
    start(32'd25000000, 32'd100000000, 8, 1'b0);
    count(400, np, ns);
    chk(np == 100, "R3 large modulo", np, 100);
    start(32'h8000_0000, 32'hFFFF_FFFF, 8, 1'b0);
    count(100, np, ns);
    chk(np == exp_pulses(100, 64'h8000_0000, 64'hFFFF_FFFF), "R3 top range", np,
        exp_pulses(100, 64'h8000_0000, 64'hFFFF_FFFF));
    start(32'hFFFF_FFFF, 32'hFFFF_FFFF, 8, 1'b0);
    count(60, np, ns);
    chk(np == 60, "R3 full ratio", np, 60);

    // R10 atomic commit
    start(32'd1, 32'd4, 8, 1'b0);
    wr(2'd1, 32'd3);
    count(40, np, ns);
    chk(np == 10, "R10 phase alone ignored", np, 10);
    wr(2'd2, 32'd4);
    count(40, np, ns);
    chk(np == 30, "R10 commit both", np, 30);

    // R1 / R6 random ratios
    for (int i = 0; i < 16; i++) begin
      int p = $urandom_range(0, 60);
      int m = $urandom_range(1, 50);
      int c = codes[$urandom_range(0, 2)];
      longint ep;
      start(32'(p), 32'(m), c, 1'b1);
      count(200, np, ns);
      ep = exp_pulses(200, p, m);
      chk(np == ep, "R1 random rate", np, ep);
      chk(ns == exp_strobes(ep, c), "R6 random strobe", ns, exp_strobes(ep, c));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule